// File: doc/BRIEF.md
# Dual Addressable Bit Latch

The block holds two banks of four storage bits. Both banks share a 2-bit address, an active-low enable and an active-low clear, and each bank has its own serial data input. The two control inputs select one of four modes. Clear forces every bit to zero. Demultiplex routes each bank's data to the addressed bit and forces the other bits to zero. Addressable write updates only the addressed bit of each bank. Hold keeps all contents. Typical uses are serial-to-parallel loading, where one bit is written per address, and steering a single data line to one of four outputs.

Storage is clocked on the rising edge. The outputs come straight from the storage flops, so every update appears one cycle after its inputs are sampled. The address is only safe to change while the block is in hold. The block therefore raises a sticky flag when it sees an address step of two or more bits while the enable is low.

Top module: `dual_addr_latch`

## Requirements
- R1: While `rst` is high at a rising edge, all eight stored bits and `addr_err` become 0 in the next cycle, whatever the other inputs are.
- R2: Clear mode (`en_n`=1, `clr_n`=0) sets `q_a` and `q_b` to 4'b0000 in the next cycle.
- R3: Demultiplex mode (`en_n`=0, `clr_n`=0) sets the addressed bit of each bank to that bank's data input and every other bit to 0. These values are stored, so a following hold keeps them.
- R4: Addressable write mode (`en_n`=0, `clr_n`=1) sets the addressed bit of each bank to its data input and leaves the other three bits of each bank unchanged.
- R5: Hold mode (`en_n`=1, `clr_n`=1) leaves `q_a` and `q_b` unchanged, whatever `addr`, `din_a` and `din_b` are.
- R6: Address value k (0 to 3) selects bit k of each output, so address 0 selects `q_a[0]`/`q_b[0]` and address 3 selects `q_a[3]`/`q_b[3]`.
- R7: Bank A uses only `din_a` and bank B uses only `din_b`, so the two banks can store different values at the same address.
- R8: `addr_err` goes to 1 in the cycle after an edge at which `en_n` is 0 and `addr` differs in two or more bits from its value at the previous edge. It then stays 1 until reset. Address changes made while `en_n` is 1 never set it.
- R9: Each update shows at the outputs exactly one cycle after the edge that sampled its inputs. The outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Shared bit address |
| en_n | input | 1 | Enable, active low |
| clr_n | input | 1 | Clear, active low |
| din_a | input | 1 | Data input of bank A |
| din_b | input | 1 | Data input of bank B |
| q_a | output | 4 | Stored bits of bank A |
| q_b | output | 4 | Stored bits of bank B |
| addr_err | output | 1 | Sticky flag for a multi-bit address step while enabled |

## Verification
The outputs are the storage itself, so any wrong stored bit shows at `q_a` or `q_b` in the very next cycle. A bit the bench expects to be held shows up there as a flip, and a bit that demultiplex should have forced low shows up there as a stale one. Later hold cycles keep a wrong value visible, so a corrupted write can still be seen after the mode moves on. A missed or spurious address-step detection shows at `addr_err` one cycle after the offending edge, and it stays latched until reset.

// File: rtl/dual_addr_latch.sv
module dual_addr_latch #(
  parameter int AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              en_n,
  input  logic              clr_n,
  input  logic              din_a,
  input  logic              din_b,
  output logic [(1<<AW)-1:0] q_a,
  output logic [(1<<AW)-1:0] q_b,
  output logic              addr_err
);
  localparam int N = 1 << AW;

  logic [N-1:0]  sel;
  logic [AW-1:0] addr_prev;
  logic          step_bad;

  assign sel      = N'(1) << addr;
  assign step_bad = !en_n && ($countones(addr ^ addr_prev) > 1);

  always_ff @(posedge clk) begin
    addr_prev <= addr;
    if (rst) begin
      q_a      <= '0;
      q_b      <= '0;
      addr_err <= 1'b0;
    end else begin
      if (step_bad) addr_err <= 1'b1;
      case ({en_n, clr_n})
        2'b10: begin
          q_a <= '0;
          q_b <= '0;
        end
        2'b00: begin
          q_a <= din_a ? sel : '0;
          q_b <= din_b ? sel : '0;
        end
        2'b01: begin
          q_a <= din_a ? (q_a | sel) : (q_a & ~sel);
          q_b <= din_b ? (q_b | sel) : (q_b & ~sel);
        end
        default: ;
      endcase
    end
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> (q_a == '0 && q_b == '0 && !addr_err));

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |=> (q_a == '0 && q_b == '0));

  assert_demux_R3: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> ((q_a == (N'($past(din_a)) << $past(addr)))
                        && (q_b == (N'($past(din_b)) << $past(addr)))));

  assert_write_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> (((q_a ^ $past(q_a)) & ~(N'(1) << $past(addr))) == '0
                       && q_a[$past(addr)] == $past(din_a)
                       && q_b[$past(addr)] == $past(din_b)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr_n) |=> ($stable(q_a) && $stable(q_b)));

  assert_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!en_n && $countones(addr ^ $past(addr)) >= 2) |=> addr_err);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> addr_err);
endmodule

// File: tb/test_dual_addr_latch.sv
module test_dual_addr_latch;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] addr;
  logic       en_n, clr_n, din_a, din_b;
  logic [3:0] q_a, q_b;
  logic       addr_err;
  int         total = 0;
  int         bad = 0;

  always #2 clk = ~clk;

  dual_addr_latch i_dual_addr_latch (
    .clk(clk), .rst(rst), .addr(addr), .en_n(en_n), .clr_n(clr_n),
    .din_a(din_a), .din_b(din_b), .q_a(q_a), .q_b(q_b), .addr_err(addr_err)
  );

  // {en_n, clr_n, addr, din_a, din_b, exp q_a, exp q_b}
  localparam logic [13:0] VEC [15] = '{
    {2'b01, 2'd0, 2'b10, 4'b0001, 4'b0000},  // R4 R6 R7 write bit0
    {2'b01, 2'd1, 2'b01, 4'b0001, 4'b0010},  // R4 R7 write bit1
    {2'b01, 2'd3, 2'b11, 4'b1001, 4'b1010},  // R4 R6 write bit3
    {2'b01, 2'd2, 2'b10, 4'b1101, 4'b1010},  // R4 write bit2
    {2'b11, 2'd2, 2'b01, 4'b1101, 4'b1010},  // R5 hold
    {2'b11, 2'd1, 2'b00, 4'b1101, 4'b1010},  // R5 R8 two-bit step in hold
    {2'b01, 2'd1, 2'b00, 4'b1101, 4'b1000},  // R4 write 0
    {2'b00, 2'd1, 2'b10, 4'b0010, 4'b0000},  // R3 demux
    {2'b11, 2'd1, 2'b11, 4'b0010, 4'b0000},  // R3 R5 stored after demux
    {2'b01, 2'd3, 2'b11, 4'b1010, 4'b1000},  // R4
    {2'b00, 2'd3, 2'b01, 4'b0000, 4'b1000},  // R3 R7
    {2'b10, 2'd3, 2'b11, 4'b0000, 4'b0000},  // R2 clear
    {2'b01, 2'd2, 2'b11, 4'b0100, 4'b0100},  // R4
    {2'b10, 2'd0, 2'b11, 4'b0000, 4'b0000},  // R2
    {2'b01, 2'd0, 2'b11, 4'b0001, 4'b0001}   // R4 R6
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got qa=%b qb=%b err=%b expected qa=%b qb=%b err=%b",
               req, act[8:5], act[4:1], act[0], exp[8:5], exp[4:1], exp[0]);
    end
  endtask

  task automatic step(input logic e, input logic c, input logic [1:0] a,
                      input logic da, input logic db);
    @(negedge clk);
    en_n = e; clr_n = c; addr = a; din_a = da; din_b = db;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1; en_n = 1'b0; clr_n = 1'b1; addr = 2'd3; din_a = 1'b1; din_b = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R1 reset dominates write", {q_a, q_b, addr_err}, 9'b0);
    @(negedge clk);
    rst = 1'b0;
    en_n = 1'b1; addr = 2'd0;
    @(posedge clk); #1;
    check("R1 reset state", {q_a, q_b, addr_err}, 9'b0);

    for (int i = 0; i < 15; i++) begin
      logic [13:0] v;
      v = VEC[i];
      step(v[13], v[12], v[11:10], v[9], v[8]);
      check($sformatf("R9 vector %0d", i), {q_a, q_b, addr_err}, {v[7:0], 1'b0});
    end

    // R9: no change before the sampling edge
    @(negedge clk);
    en_n = 1'b0; clr_n = 1'b1; addr = 2'd1; din_a = 1'b1; din_b = 1'b0;
    #1;
    check("R9 before edge", {q_a, q_b, addr_err}, {4'b0001, 4'b0001, 1'b0});
    @(posedge clk); #1;
    check("R9 after edge", {q_a, q_b, addr_err}, {4'b0011, 4'b0001, 1'b0});

    // R3: demux with zero data clears both banks
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    check("R3 demux zero", {q_a, q_b, addr_err}, 9'b0);

    // R8: two-bit step 0 -> 3 while enabled
    step(1'b0, 1'b1, 2'd3, 1'b1, 1'b0);
    check("R8 step flagged", {q_a, q_b, addr_err}, {4'b1000, 4'b0000, 1'b1});
    step(1'b1, 1'b1, 2'd3, 1'b0, 1'b0);
    check("R8 sticky", {q_a, q_b, addr_err}, {4'b1000, 4'b0000, 1'b1});

    // R1: reset clears the flag and data
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset clears flag", {q_a, q_b, addr_err}, 9'b0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 1'b1, 2'd2, 1'b0, 1'b1);
    check("R8 one-bit step ok", {q_a, q_b, addr_err}, {4'b0000, 4'b0100, 1'b0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule